// File: doc/BRIEF.md
# SPI Master with Delayed Sampling

This block is a master-side serial transfer engine clocked by the system clock. Software-side logic pushes data words into a small transmit queue. The engine takes one word at a time and appends a parity bit. It shifts the frame out most significant bit first on `sout` while toggling `sck`, and it gathers the bits arriving on `sin` into a receive queue. Each received frame has its parity checked. A parity failure sets a sticky flag and can optionally freeze the frame stream.

There are two capture timings. In the normal timing, `sin` is taken on every rising `sck` edge. In the modified timing, `sin` is taken at the falling (driving) edge, or one or two system clocks after it. This lets the master tolerate a long round-trip delay on slow links. The timing choice, the sample delay and the parity sense are latched when a frame starts. Either queue can be narrowed to a single entry, which turns that side into a plain double-buffered port. Either queue can also be emptied with a one-cycle clear pulse.

The sequencer has four states. `ST_IDLE` keeps `sck` low. It leaves for `ST_LOW` when a word is queued, `halt` is low, and no parity stop is in force (load: the word is popped and the frame is built). `ST_LOW` holds `sck` low for half a period, then moves to `ST_HIGH` (rising edge). `ST_HIGH` holds `sck` high for half a period, then produces a falling edge. From there it returns to `ST_LOW` for the next bit, or goes to `ST_DRAIN` after the parity bit. `ST_DRAIN` waits until any delayed sample has been taken. It then hands the frame to the receive queue and returns to `ST_IDLE`.

Top module: `spim_top`

## Requirements
- R1: After reset, `sck`, `sout` and `busy` are 0, both queue counts are 0, and `tx_ovf`, `rx_ovf` and `par_err` are 0.
- R2: A frame is DATA_W data bits, most significant first, followed by one parity bit. With `odd_par`=0 the parity bit makes the count of ones in the frame even; with `odd_par`=1 it makes it odd. `sout` carries each bit before the rising `sck` edge that presents it. `sck` idles low, and each level lasts DIV/2 system clocks.
- R3: With `mod_timing`=0, the receiver captures `sin` at every rising `sck` edge. The received data word is the first DATA_W captured bits, most significant first.
- R4: With `mod_timing`=1, the receiver captures `sin` at each falling `sck` edge, delayed by `smpl_sel` system clocks: code 0 means no delay, 1 means one clock and 2 means two clocks. Code 3 behaves like code 0.
- R5: A new frame begins only while `halt` is 0. Raising `halt` during a frame lets that frame finish, and no further frame starts.
- R6: A received frame whose count of ones has the wrong parity for `odd_par` sets `par_err`. The flag holds until `perr_clr` is pulsed.
- R7: While `pe_stop`=1 and `par_err`=1, no new frame starts. With `pe_stop`=0, frames keep flowing despite `par_err`.
- R8: The transmit queue holds DEPTH words in order; with `tx_dis`=1 it holds one pending word besides the frame being shifted. A write to a full queue is dropped and sets the sticky `tx_ovf`.
- R9: The receive queue holds DEPTH words, and `rx_rdata` shows the oldest. `rx_rd` removes that word. With `rx_dis`=1 the queue holds one word. A frame arriving when the queue is full is discarded and sets the sticky `rx_ovf`.
- R10: A `tx_clr` pulse empties the transmit queue and clears `tx_ovf` by the next cycle, and it overrides a write in the same cycle. `rx_clr` does the same for the receive side. Neither pulse is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt | input | 1 | 1 prevents new frames from starting |
| pe_stop | input | 1 | 1 freezes the stream while `par_err` is set |
| odd_par | input | 1 | 0 even parity, 1 odd parity |
| mod_timing | input | 1 | 1 selects falling-edge delayed capture |
| smpl_sel | input | 2 | Capture delay in modified timing (3 acts as 0) |
| tx_dis | input | 1 | 1 narrows the transmit queue to one entry |
| rx_dis | input | 1 | 1 narrows the receive queue to one entry |
| tx_clr | input | 1 | Pulse: empty transmit queue, clear `tx_ovf` |
| rx_clr | input | 1 | Pulse: empty receive queue, clear `rx_ovf` |
| perr_clr | input | 1 | Pulse: clear `par_err` |
| tx_wr | input | 1 | Push `tx_wdata` into the transmit queue |
| tx_wdata | input | DATA_W | Word to transmit |
| rx_rd | input | 1 | Remove the oldest received word |
| rx_rdata | output | DATA_W | Oldest received word |
| tx_count | output | $clog2(DEPTH+1) | Words waiting to be sent |
| rx_count | output | $clog2(DEPTH+1) | Words waiting to be read |
| tx_ovf | output | 1 | Sticky: write dropped on full queue |
| rx_ovf | output | 1 | Sticky: frame dropped on full queue |
| par_err | output | 1 | Sticky: received parity mismatch |
| busy | output | 1 | A frame is in progress |
| sck | output | 1 | Serial clock |
| sout | output | 1 | Serial data out |
| sin | input | 1 | Serial data in |

## Verification
The assertions cover the rules that hold on every cycle. They check that `sck` is low outside a frame and that no frame starts under `halt` or under a parity stop. They also check that the queue counts stay in range, that the overflow flags are sticky, and that the clear pulses empty the queues on the next cycle. Only the bench scenarios can show that the bits on `sout` and the captured `sin` values are right. The bench models which system clock each capture lands on for every delay code, and it checks queue ordering, discard on overflow, and the exact number of frames sent before a halt or a parity stop takes hold.

// File: rtl/spim_pkg.sv
package spim_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_DRAIN
    } spim_state_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         cap_one,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         ovf
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          full, do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = cap_one ? (count != '0) : (count == CW'(DEPTH));
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && (count != '0) && !clr;
    assign dout    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (push && full) ovf <= 1'b1;
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
    import spim_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DIV    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_ok,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              odd_par,
    input  logic              mod_timing,
    input  logic [1:0]        smpl_sel,
    input  logic              sin,
    output logic              load,
    output logic              sck,
    output logic              sout,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_word,
    output logic              rx_perr
);
    localparam int FW   = DATA_W + 1;
    localparam int HALF = DIV / 2;
    localparam int HW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int BW   = $clog2(FW + 1);

    spim_state_t     state, nxt;
    logic [HW-1:0]   hcnt;
    logic [BW-1:0]   bit_idx;
    logic [FW-1:0]   tx_sh, rx_sh;
    logic            pend, mod_q, odd_q;
    logic [1:0]      dly, smpl_q, dsel;
    logic            hdone, last_bit, rise, fall, cap_now;

    assign hdone    = (hcnt == HW'(HALF - 1));
    assign last_bit = (bit_idx == BW'(FW - 1));
    assign rise     = (state == ST_LOW)  && hdone;
    assign fall     = (state == ST_HIGH) && hdone;
    assign load     = (state == ST_IDLE) && start_ok;
    assign dsel     = (smpl_q == 2'b11) ? 2'b00 : smpl_q;
    assign cap_now  = (!mod_q && rise) || (mod_q && fall && dsel == 2'b00)
                    || (pend && dly == 2'd1);
    assign done     = (state == ST_DRAIN) && !pend;
    assign rx_word  = rx_sh[FW-1:1];
    assign rx_perr  = (^rx_sh) != odd_q;
    assign sout     = tx_sh[FW-1];
    assign busy     = (state != ST_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start_ok) nxt = ST_LOW;
            ST_LOW:   if (hdone) nxt = ST_HIGH;
            ST_HIGH:  if (hdone) nxt = last_bit ? ST_DRAIN : ST_LOW;
            ST_DRAIN: if (!pend) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt    <= '0;
            bit_idx <= '0;
            sck     <= 1'b0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            pend    <= 1'b0;
            dly     <= '0;
            mod_q   <= 1'b0;
            odd_q   <= 1'b0;
            smpl_q  <= '0;
        end else begin
            hcnt <= ((state == ST_LOW || state == ST_HIGH) && !hdone) ? hcnt + 1'b1 : '0;
            if (load) begin
                tx_sh   <= {tx_word, odd_par ? ~^tx_word : ^tx_word};
                bit_idx <= '0;
                mod_q   <= mod_timing;
                odd_q   <= odd_par;
                smpl_q  <= smpl_sel;
            end
            if (rise) sck <= 1'b1;
            if (fall) begin
                sck     <= 1'b0;
                tx_sh   <= {tx_sh[FW-2:0], 1'b0};
                bit_idx <= bit_idx + 1'b1;
            end
            if (cap_now) rx_sh <= {rx_sh[FW-2:0], sin};
            if (mod_q && fall && dsel != 2'b00) begin
                pend <= 1'b1;
                dly  <= dsel;
            end else if (pend) begin
                if (dly == 2'd1) pend <= 1'b0;
                dly <= dly - 1'b1;
            end
        end
    end
endmodule

// File: rtl/spim_top.sv
module spim_top #(
    parameter int DATA_W = 16,
    parameter int DIV    = 6,
    parameter int DEPTH  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        halt,
    input  logic                        pe_stop,
    input  logic                        odd_par,
    input  logic                        mod_timing,
    input  logic [1:0]                  smpl_sel,
    input  logic                        tx_dis,
    input  logic                        rx_dis,
    input  logic                        tx_clr,
    input  logic                        rx_clr,
    input  logic                        perr_clr,
    input  logic                        tx_wr,
    input  logic [DATA_W-1:0]           tx_wdata,
    input  logic                        rx_rd,
    output logic [DATA_W-1:0]           rx_rdata,
    output logic [$clog2(DEPTH+1)-1:0]  tx_count,
    output logic [$clog2(DEPTH+1)-1:0]  rx_count,
    output logic                        tx_ovf,
    output logic                        rx_ovf,
    output logic                        par_err,
    output logic                        busy,
    output logic                        sck,
    output logic                        sout,
    input  logic                        sin
);
    logic [DATA_W-1:0] tx_head, rx_word;
    logic              start_ok, load, done, rx_perr;

    assign start_ok = (tx_count != '0) && !halt && !(pe_stop && par_err);

    spim_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr), .cap_one(tx_dis),
        .push(tx_wr), .din(tx_wdata), .pop(load),
        .dout(tx_head), .count(tx_count), .ovf(tx_ovf)
    );

    spim_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .cap_one(rx_dis),
        .push(done), .din(rx_word), .pop(rx_rd),
        .dout(rx_rdata), .count(rx_count), .ovf(rx_ovf)
    );

    spim_shifter #(.DATA_W(DATA_W), .DIV(DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .tx_word(tx_head),
        .odd_par(odd_par), .mod_timing(mod_timing), .smpl_sel(smpl_sel),
        .sin(sin), .load(load), .sck(sck), .sout(sout), .busy(busy),
        .done(done), .rx_word(rx_word), .rx_perr(rx_perr)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                par_err <= 1'b0;
        else if (done && rx_perr)  par_err <= 1'b1;
        else if (perr_clr)         par_err <= 1'b0;
    end
endmodule

// File: rtl/spim_chk.sv
module spim_chk #(
    parameter int DEPTH = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        halt,
    input logic                        pe_stop,
    input logic                        par_err,
    input logic                        busy,
    input logic                        sck,
    input logic                        tx_clr,
    input logic                        rx_clr,
    input logic [$clog2(DEPTH+1)-1:0]  tx_count,
    input logic [$clog2(DEPTH+1)-1:0]  rx_count,
    input logic                        tx_ovf,
    input logic                        rx_ovf
);
    AST_IDLE_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !sck); // R2
    AST_HALT_NO_START: assert property (@(posedge clk) disable iff (!rst_n) (!busy && halt) |=> !busy); // R5
    AST_PERR_NO_START: assert property (@(posedge clk) disable iff (!rst_n) (!busy && pe_stop && par_err) |=> !busy); // R7
    AST_TX_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) int'(tx_count) <= DEPTH); // R8
    AST_RX_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) int'(rx_count) <= DEPTH); // R9
    AST_TX_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (tx_ovf && !tx_clr) |=> tx_ovf); // R8
    AST_RX_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (rx_ovf && !rx_clr) |=> rx_ovf); // R9
    AST_TX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) tx_clr |=> (tx_count == '0 && !tx_ovf)); // R10
    AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) rx_clr |=> (rx_count == '0 && !rx_ovf)); // R10
endmodule

bind spim_top spim_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_spim_top.sv
module tb_spim_top;
    localparam int DATA_W = 16;
    localparam int DIV    = 6;
    localparam int DEPTH  = 4;
    localparam int FW     = DATA_W + 1;
    localparam int CW     = $clog2(DEPTH + 1);
    localparam int FRM    = FW * DIV + 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt = 0, pe_stop = 0, odd_par = 0, mod_timing = 0;
    logic [1:0] smpl_sel = 0;
    logic tx_dis = 0, rx_dis = 0, tx_clr = 0, rx_clr = 0, perr_clr = 0;
    logic tx_wr = 0, rx_rd = 0, sin = 0;
    logic [DATA_W-1:0] tx_wdata = 0;
    logic [DATA_W-1:0] rx_rdata;
    logic [CW-1:0] tx_count, rx_count;
    logic tx_ovf, rx_ovf, par_err, busy, sck, sout;

    always #10 clk = ~clk;

    spim_top #(.DATA_W(DATA_W), .DIV(DIV), .DEPTH(DEPTH)) dut (.*);

    int n_cmp = 0, n_bad = 0, n_rise = 0;
    longint cyc = 0;
    int sin_mode = 0;
    bit finished = 0;

    logic [DATA_W-1:0] m_tx[$], m_rx[$];
    bit m_txovf = 0, m_rxovf = 0, m_perr = 0;
    logic [DATA_W-1:0] cur_word;
    logic [FW-1:0] cur_frame, rx_acc;
    int tx_bit = 0, rx_n = 0;
    logic prev_sck = 0;

    function automatic logic sin_fn(longint k);
        logic [31:0] h;
        h = k[31:0] * 32'h9E3779B1;
        return (sin_mode == 0) ? 1'b0 : (h[17] ^ h[5]);
    endfunction

    task automatic chk(string req, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    task automatic add_bit(logic b);
        rx_acc = {rx_acc[FW-2:0], b};
        rx_n++;
        if (rx_n == FW) begin
            rx_n = 0;
            if ((^rx_acc) != odd_par) m_perr = 1;
            if (m_rx.size() >= (rx_dis ? 1 : DEPTH)) m_rxovf = 1;
            else m_rx.push_back(rx_acc[FW-1:1]);
        end
    endtask

    // reference model, evaluated every clock at the falling clk edge
    always @(negedge clk) begin
        sin <= sin_fn(cyc + 1);
        if (rst_n) begin
            if (sck && !prev_sck) begin
                n_rise++;
                if (tx_bit == 0) begin
                    if (m_tx.size() == 0) chk("R2 frame without queued word", 1, 0);
                    else begin
                        cur_word = m_tx.pop_front();
                        cur_frame = {cur_word, odd_par ? ~^cur_word : ^cur_word};
                    end
                end
                chk("R2 sout bit", sout, cur_frame[FW-1-tx_bit]);
                tx_bit = (tx_bit == FW - 1) ? 0 : tx_bit + 1;
                if (!mod_timing) add_bit(sin_fn(cyc));
            end
            if (!sck && prev_sck && mod_timing)
                add_bit(sin_fn(cyc + ((smpl_sel == 2'b11) ? 0 : smpl_sel)));
            prev_sck = sck;
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [DATA_W-1:0] w);
        @(negedge clk);
        tx_wr = 1; tx_wdata = w;
        if (m_tx.size() >= (tx_dis ? 1 : DEPTH)) m_txovf = 1;
        else m_tx.push_back(w);
        @(negedge clk);
        tx_wr = 0;
    endtask

    task automatic rd(string req);
        @(negedge clk);
        if (m_rx.size() == 0) chk(req, rx_count, 0);
        else chk(req, rx_rdata, m_rx.pop_front());
        rx_rd = 1;
        @(negedge clk);
        rx_rd = 0;
    endtask

    task automatic pulse_clr_tx();
        @(negedge clk); tx_clr = 1; m_tx.delete(); m_txovf = 0;
        @(negedge clk); tx_clr = 0;
    endtask

    task automatic pulse_clr_rx();
        @(negedge clk); rx_clr = 1; m_rx.delete(); m_rxovf = 0;
        @(negedge clk); rx_clr = 0;
    endtask

    task automatic pulse_perr();
        @(negedge clk); perr_clr = 1; m_perr = 0;
        @(negedge clk); perr_clr = 0;
    endtask

    task automatic check_model(string req);
        @(negedge clk);
        chk({req, " tx_count"}, tx_count, m_tx.size());
        chk({req, " rx_count"}, rx_count, m_rx.size());
        chk({req, " tx_ovf"}, tx_ovf, m_txovf);
        chk({req, " rx_ovf"}, rx_ovf, m_rxovf);
        chk({req, " par_err"}, par_err, m_perr);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int r0;
        step(4);
        rst_n = 1;
        step(2);
        // R1 reset state
        chk("R1 sck", sck, 0);
        chk("R1 sout", sout, 0);
        chk("R1 busy", busy, 0);
        check_model("R1");

        // R3 normal timing, R8 ordering
        sin_mode = 1;
        wr(16'hA5F0); wr(16'h1234); wr(16'hFFFF);
        step(3 * FRM + 20);
        check_model("R3 R6 R8");
        rd("R3 word0"); rd("R3 word1"); rd("R3 word2");
        pulse_perr();

        // R4 modified timing, each sample code
        mod_timing = 1;
        for (int s = 0; s < 4; s++) begin
            smpl_sel = 2'(s);
            wr(16'h3C5A ^ 16'(s));
            step(FRM + 10);
            check_model("R4 counts");
            rd("R4 delayed capture");
            pulse_perr();
        end
        mod_timing = 0;
        smpl_sel = 0;

        // R5 halt before start
        halt = 1;
        r0 = n_rise;
        wr(16'h0F0F); wr(16'hF0F0);
        step(300);
        chk("R5 no frame while halted", n_rise, r0);
        chk("R5 queue held", tx_count, 2);
        halt = 0;
        step(2 * FRM + 20);
        check_model("R5 resumed");
        rd("R5 w0"); rd("R5 w1");
        pulse_perr();

        // R5 halt mid-frame
        wr(16'h1111); wr(16'h2222);
        step(20);
        halt = 1;
        step(300);
        chk("R5 current frame completes", rx_count, 1);
        chk("R5 next frame blocked", tx_count, 1);
        halt = 0;
        step(FRM + 20);
        check_model("R5 mid-frame");
        rd("R5 m0"); rd("R5 m1");
        pulse_perr();

        // R8 overflow, R10 clear
        halt = 1;
        for (int i = 0; i < 5; i++) wr(16'h4000 + 16'(i));
        check_model("R8 full");
        chk("R8 overflow flag", tx_ovf, 1);
        pulse_clr_tx();
        check_model("R10 tx clear");
        tx_dis = 1;
        wr(16'h5555); wr(16'h6666);
        chk("R8 single entry", tx_count, 1);
        check_model("R8 narrow");
        @(negedge clk); tx_wr = 1; tx_clr = 1; tx_wdata = 16'h7777; m_tx.delete(); m_txovf = 0;
        @(negedge clk); tx_wr = 0; tx_clr = 0;
        chk("R10 clear beats write", tx_count, 0);
        halt = 0;

        // R8 double buffer while shifting
        wr(16'h8181);
        step(10);
        wr(16'h9292);
        chk("R8 one pending while shifting", tx_count, 1);
        chk("R8 no overflow yet", tx_ovf, 0);
        wr(16'hA3A3);
        chk("R8 second pending drops", tx_ovf, 1);
        step(2 * FRM + 20);
        check_model("R8 double buffer");
        rd("R8 d0"); rd("R8 d1");
        pulse_clr_tx();
        pulse_perr();
        tx_dis = 0;

        // R9 receive overflow
        halt = 1;
        for (int i = 0; i < 4; i++) wr(16'hC000 + 16'(i));
        halt = 0;
        step(10);
        wr(16'hC004);
        step(5 * FRM + 20);
        chk("R9 rx full", rx_count, DEPTH);
        chk("R9 rx overflow", rx_ovf, 1);
        check_model("R9");
        rd("R9 oldest first");
        pulse_clr_rx();
        check_model("R10 rx clear");
        pulse_perr();
        rx_dis = 1;
        halt = 1;
        wr(16'hD001); wr(16'hD002);
        halt = 0;
        step(2 * FRM + 20);
        chk("R9 single holding", rx_count, 1);
        check_model("R9 narrow");
        rd("R9 first kept");
        pulse_clr_rx();
        pulse_perr();
        rx_dis = 0;

        // R6 R7 parity stop: all-zero input with odd parity fails
        sin_mode = 0;
        odd_par = 1;
        pe_stop = 1;
        halt = 1;
        wr(16'h0001); wr(16'h0002); wr(16'h0003);
        halt = 0;
        step(3 * FRM + 40);
        chk("R7 stop after error", tx_count, 2);
        chk("R6 error flag", par_err, 1);
        chk("R7 one frame in", rx_count, 1);
        pulse_perr();
        step(3 * FRM);
        chk("R7 one more then stop", tx_count, 1);
        chk("R6 error again", par_err, 1);
        pe_stop = 0;
        step(FRM + 20);
        chk("R7 flow without stop", tx_count, 0);
        check_model("R7");
        rd("R6 z0"); rd("R6 z1"); rd("R6 z2");
        pulse_perr();

        // R6 even parity on zeros is clean
        odd_par = 0;
        wr(16'h00FF);
        step(FRM + 20);
        chk("R6 no error", par_err, 0);
        check_model("R6 clean");
        rd("R6 clean word");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule